// File: doc/BRIEF.md
# Threshold Burst Request and Drain Controller

This block holds a receive byte queue and a transmit byte queue between a serial bus engine and a host processor or DMA engine. The bus engine pushes received bytes into the receive queue and pulls bytes to send from the transmit queue. The host reads and writes single bytes through plain strobes. Host reads and writes are moved in bursts of threshold plus one bytes. The block compares each queue level and the remaining transfer length against programmable thresholds. From that comparison it raises sticky request flags and two DMA request lines.

A transfer may be shorter than a whole number of bursts. Draining flags cover that case and tell the host how many bytes are left, so it makes exactly the accesses still needed. A read from an empty receive queue or a write to a full transmit queue is refused, and an access-error flag is raised. All flags are cleared by writing 1. Either queue can be emptied on its own by a clear control.

Both bus-side ports are valid/ready streams. A receive byte is taken on a clock edge where `rx_in_valid` and `rx_in_ready` are both high. `rx_in_ready` is low while the receive queue is full, and a byte offered then is not stored. The sender must hold the byte and its valid until it is taken. `tx_out_valid` is high whenever the transmit queue holds a byte, and `tx_out_data` shows the oldest byte. That byte leaves on an edge where `tx_out_ready` is also high.

Top module: `fqd_ctrl`

## Requirements
- R1: After reset both queue levels are 0, all five flags and both DMA requests are 0, `rx_in_ready` is 1, `tx_out_valid` is 0, and `fifo_depth` reads DEPTH (32 by default).
- R2: Each queue keeps byte order. Its level never exceeds DEPTH. While the receive queue is full, `rx_in_ready` is 0 and offered bytes are dropped without changing the level.
- R3: The receive-ready flag (bit 0 of `flags`) sets when the receive level is at least `rx_thr`+1.
- R4: The transmit-ready flag (bit 1) sets when the transmit level is at most `tx_thr` and at least `tx_thr`+1 bytes remain for the host to write.
- R5: Writing 1 to a bit of `flag_clr` clears that flag on the next edge. If its condition still holds, the flag sets again one cycle later.
- R6: With `dma_rx_en` high, `dma_rx_req` rises once the receive level exceeds `rx_thr`. It falls on the edge of the (`rx_thr`+1)-th accepted host read.
- R7: With `dma_tx_en` high, `dma_tx_req` rises when the transmit queue is empty. It falls on the edge of the (`tx_thr`+1)-th accepted host write, and stays high while fewer have been written.
- R8: The receive-drain flag (bit 2) sets on an `xfer_end` pulse when `drain_en_rx` is 1 and the receive level is between 1 and `rx_thr`. `rx_level` gives the bytes left to read.
- R9: The transmit-drain flag (bit 3) sets when `drain_en_tx` is 1 and `host_left` is between 1 and `tx_thr`.
- R10: The access-error flag (bit 4) sets on a host read while the receive queue is empty, or a host write while the transmit queue is full. The refused access leaves the level unchanged.
- R11: `rx_clr` empties the receive queue and drops `dma_rx_req`. `tx_clr` does the same for the transmit queue and `dma_tx_req`.
- R12: `xfer_start` loads `bus_left` with `xfer_len`. It loads `host_left` with `xfer_len` if `xfer_dir_tx` is 1, and with 0 otherwise. `bus_left` decrements once per cycle in which a byte crosses the bus. `host_left` decrements per accepted host write. Both stop at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_in_valid | input | 1 | Bus engine offers a received byte |
| rx_in_ready | output | 1 | Receive queue can take a byte |
| rx_in_data | input | 8 | Received byte |
| tx_out_valid | output | 1 | Transmit queue has a byte |
| tx_out_ready | input | 1 | Bus engine takes the byte |
| tx_out_data | output | 8 | Oldest transmit byte |
| host_rd | input | 1 | Host/DMA read strobe |
| host_rd_data | output | 8 | Oldest receive byte |
| host_wr | input | 1 | Host/DMA write strobe |
| host_wr_data | input | 8 | Byte to write |
| rx_thr | input | AW | Receive threshold (burst = value+1) |
| tx_thr | input | AW | Transmit threshold (burst = value+1) |
| xfer_len | input | CW | Transfer length in bytes |
| xfer_dir_tx | input | 1 | Transfer sends data (1) or receives (0) |
| xfer_start | input | 1 | Transfer start pulse |
| xfer_end | input | 1 | Transfer end pulse |
| drain_en_rx | input | 1 | Enable receive draining |
| drain_en_tx | input | 1 | Enable transmit draining |
| dma_rx_en | input | 1 | Enable receive DMA request |
| dma_tx_en | input | 1 | Enable transmit DMA request |
| rx_clr | input | 1 | Empty the receive queue |
| tx_clr | input | 1 | Empty the transmit queue |
| flag_clr | input | 5 | Write-1-to-clear flag strobes |
| flags | output | 5 | Sticky flags: 0 rx-ready, 1 tx-ready, 2 rx-drain, 3 tx-drain, 4 access error |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |
| rx_level | output | LW | Receive queue level |
| tx_level | output | LW | Transmit queue level |
| host_left | output | CW | Bytes the host still has to write |
| bus_left | output | CW | Bytes still to cross the bus |
| fifo_depth | output | LW | Queue depth constant |

## Verification
A table of receive patterns crosses threshold values with byte counts: exactly at threshold, one above, zero, full and overfull. This separates an off-by-one in the ready comparison from one in the drain window, and tests saturation at full. Directed sequences move partial and complete DMA bursts, which tell a request that drops early from one that never drops. They also re-check a flag one and two cycles after its clear, which separates a plain clear from the required re-set. A short transmit transfer walks `host_left` through the ready and drain windows, and refused accesses on an empty and a full queue confirm the levels stay put.

// File: rtl/fqd_pkg.sv
package fqd_pkg;
  localparam int NFLAG    = 5;
  localparam int F_RXRDY  = 0;
  localparam int F_TXRDY  = 1;
  localparam int F_RXDRN  = 2;
  localparam int F_TXDRN  = 3;
  localparam int F_ACCERR = 4;
  typedef logic [7:0] byte_t;
endpackage

// File: rtl/fqd_fifo.sv
module fqd_fifo #(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            push,
  input  fqd_pkg::byte_t  push_data,
  input  logic            pop,
  output fqd_pkg::byte_t  head,
  output logic [LW-1:0]   level,
  output logic            empty,
  output logic            full,
  output logic            push_ok,
  output logic            pop_ok
);
  fqd_pkg::byte_t mem [DEPTH];
  logic [AW-1:0]  wptr, rptr;

  assign empty   = (level == '0);
  assign full    = (level == LW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push_ok) wptr <= wptr + AW'(1);
      if (pop_ok)  rptr <= rptr + AW'(1);
      case ({push_ok, pop_ok})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end
  end

  // R2
  lvl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  // R2
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full && push && !pop && !clr |=> full);

  // R10
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty && pop && !push && !clr |=> empty);
endmodule

// File: rtl/fqd_burst.sv
module fqd_burst #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic          trig,
  input  logic          move,
  input  logic [AW-1:0] thr,
  output logic          req
);
  logic [AW-1:0] moved;

  always_ff @(posedge clk) begin
    if (!rst_n || clr || !en) begin
      req   <= 1'b0;
      moved <= '0;
    end else if (!req) begin
      if (trig) begin
        req   <= 1'b1;
        moved <= '0;
      end
    end else if (move) begin
      if (moved == thr) begin
        req   <= 1'b0;
        moved <= '0;
      end else begin
        moved <= moved + AW'(1);
      end
    end
  end

  // R6
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> $past(trig && en));

  // R7
  burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req && !move && en && !clr |=> req);

  // R11
  clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !req);
endmodule

// File: rtl/fqd_ctrl.sv
module fqd_ctrl #(
  parameter int DEPTH = 32,
  parameter int CW = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rx_in_valid,
  output logic                      rx_in_ready,
  input  logic [7:0]                rx_in_data,
  output logic                      tx_out_valid,
  input  logic                      tx_out_ready,
  output logic [7:0]                tx_out_data,
  input  logic                      host_rd,
  output logic [7:0]                host_rd_data,
  input  logic                      host_wr,
  input  logic [7:0]                host_wr_data,
  input  logic [AW-1:0]             rx_thr,
  input  logic [AW-1:0]             tx_thr,
  input  logic [CW-1:0]             xfer_len,
  input  logic                      xfer_dir_tx,
  input  logic                      xfer_start,
  input  logic                      xfer_end,
  input  logic                      drain_en_rx,
  input  logic                      drain_en_tx,
  input  logic                      dma_rx_en,
  input  logic                      dma_tx_en,
  input  logic                      rx_clr,
  input  logic                      tx_clr,
  input  logic [fqd_pkg::NFLAG-1:0] flag_clr,
  output logic [fqd_pkg::NFLAG-1:0] flags,
  output logic                      dma_rx_req,
  output logic                      dma_tx_req,
  output logic [LW-1:0]             rx_level,
  output logic [LW-1:0]             tx_level,
  output logic [CW-1:0]             host_left,
  output logic [CW-1:0]             bus_left,
  output logic [LW-1:0]             fifo_depth
);
  import fqd_pkg::*;

  logic rx_empty, rx_full, rx_push_ok, rx_pop_ok;
  logic tx_empty, tx_full, tx_push_ok, tx_pop_ok;
  logic [NFLAG-1:0] flag_set;
  logic [LW-1:0] rx_thr_w, tx_thr_w;
  logic [CW-1:0] tx_burst;

  assign fifo_depth   = LW'(DEPTH);
  assign rx_in_ready  = !rx_full;
  assign tx_out_valid = !tx_empty;
  assign rx_thr_w     = {1'b0, rx_thr};
  assign tx_thr_w     = {1'b0, tx_thr};
  assign tx_burst     = CW'(tx_thr) + CW'(1);

  fqd_fifo #(.DEPTH(DEPTH)) i_rxq (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr),
    .push(rx_in_valid), .push_data(rx_in_data),
    .pop(host_rd), .head(host_rd_data),
    .level(rx_level), .empty(rx_empty), .full(rx_full),
    .push_ok(rx_push_ok), .pop_ok(rx_pop_ok)
  );

  fqd_fifo #(.DEPTH(DEPTH)) i_txq (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr),
    .push(host_wr), .push_data(host_wr_data),
    .pop(tx_out_ready), .head(tx_out_data),
    .level(tx_level), .empty(tx_empty), .full(tx_full),
    .push_ok(tx_push_ok), .pop_ok(tx_pop_ok)
  );

  fqd_burst #(.AW(AW)) i_rxdma (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr), .en(dma_rx_en),
    .trig(rx_level > rx_thr_w), .move(rx_pop_ok), .thr(rx_thr),
    .req(dma_rx_req)
  );

  fqd_burst #(.AW(AW)) i_txdma (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr), .en(dma_tx_en),
    .trig(tx_empty), .move(tx_push_ok), .thr(tx_thr),
    .req(dma_tx_req)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_left  <= '0;
      host_left <= '0;
    end else if (xfer_start) begin
      bus_left  <= xfer_len;
      host_left <= xfer_dir_tx ? xfer_len : '0;
    end else begin
      if ((rx_push_ok || tx_pop_ok) && bus_left != '0)
        bus_left <= bus_left - CW'(1);
      if (tx_push_ok && host_left != '0)
        host_left <= host_left - CW'(1);
    end
  end

  always_comb begin
    flag_set           = '0;
    flag_set[F_RXRDY]  = rx_level > rx_thr_w;
    flag_set[F_TXRDY]  = (tx_level <= tx_thr_w) && (host_left >= tx_burst);
    flag_set[F_RXDRN]  = xfer_end && drain_en_rx && !rx_empty &&
                         (rx_level <= rx_thr_w);
    flag_set[F_TXDRN]  = drain_en_tx && (host_left != '0) &&
                         (host_left <= CW'(tx_thr));
    flag_set[F_ACCERR] = (host_rd && rx_empty) || (host_wr && tx_full);
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)           flags[g] <= 1'b0;
      else if (flag_clr[g]) flags[g] <= 1'b0;
      else if (flag_set[g]) flags[g] <= 1'b1;
    end
  end

  // R5
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|flag_clr) |=> ((flags & $past(flag_clr)) == '0));

  // R10
  aerr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && rx_empty && !flag_clr[F_ACCERR] |=> flags[F_ACCERR]);

  // R12
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> bus_left == $past(xfer_len));

  // R3
  rxrdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level > rx_thr_w) && !flag_clr[F_RXRDY] |=> flags[F_RXRDY]);
endmodule

// File: tb/test_fqd_ctrl.sv
`timescale 1ns/1ps
module test_fqd_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_in_valid = 0, tx_out_ready = 0, host_rd = 0, host_wr = 0;
  logic [7:0] rx_in_data = 0, host_wr_data = 0;
  logic [4:0] rx_thr = 0, tx_thr = 0;
  logic [15:0] xfer_len = 0;
  logic xfer_dir_tx = 0, xfer_start = 0, xfer_end = 0;
  logic drain_en_rx = 0, drain_en_tx = 0, dma_rx_en = 0, dma_tx_en = 0;
  logic rx_clr = 0, tx_clr = 0;
  logic [4:0] flag_clr = 0;
  logic rx_in_ready, tx_out_valid, dma_rx_req, dma_tx_req;
  logic [7:0] tx_out_data, host_rd_data;
  logic [4:0] flags;
  logic [5:0] rx_level, tx_level, fifo_depth;
  logic [15:0] host_left, bus_left;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fqd_ctrl i_fqd_ctrl (.*);

  // thr, pushes, expected level, expected {rx-ready, rx-drain}
  localparam logic [31:0] RXV [8] = '{
    {8'd3, 8'd3, 8'd3, 8'h1}, {8'd3, 8'd4, 8'd4, 8'h2},
    {8'd0, 8'd1, 8'd1, 8'h2}, {8'd0, 8'd0, 8'd0, 8'h0},
    {8'd7, 8'd2, 8'd2, 8'h1}, {8'd31, 8'd32, 8'd32, 8'h2},
    {8'd31, 8'd31, 8'd31, 8'h1}, {8'd5, 8'd40, 8'd32, 8'h2}};

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push_rx(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      rx_in_valid = 1; rx_in_data = 8'(base + i); tick(1);
    end
    rx_in_valid = 0;
  endtask

  task automatic hread();
    host_rd = 1; tick(1); host_rd = 0;
  endtask

  task automatic hwrite(input int d);
    host_wr = 1; host_wr_data = 8'(d); tick(1); host_wr = 0;
  endtask

  task automatic clr_flags();
    flag_clr = 5'h1f; tick(1); flag_clr = 0;
  endtask

  task automatic rxclr();
    rx_clr = 1; tick(1); rx_clr = 0;
  endtask

  task automatic txclr();
    tx_clr = 1; tick(1); tx_clr = 0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: got running expected finished");
    summary();
  end

  initial begin
    tick(3); rst_n = 1; tick(1);
    // R1 reset state
    chk("R1 flags", flags, 0);
    chk("R1 dma_rx", dma_rx_req, 0);
    chk("R1 dma_tx", dma_tx_req, 0);
    chk("R1 rx_level", rx_level, 0);
    chk("R1 tx_level", tx_level, 0);
    chk("R1 depth", fifo_depth, 32);
    chk("R1 rx_ready", rx_in_ready, 1);
    chk("R1 tx_valid", tx_out_valid, 0);

    // table: R3 ready, R8 drain, R2 saturation
    drain_en_rx = 1;
    for (int v = 0; v < 8; v++) begin
      rxclr();
      rx_thr = 5'(RXV[v][31:24]);
      tick(1); clr_flags();
      push_rx(int'(RXV[v][23:16]), 0);
      tick(2);
      chk("R2 level", rx_level, int'(RXV[v][15:8]));
      chk("R3 rx-ready", flags[0], int'(RXV[v][1]));
      xfer_end = 1; tick(1); xfer_end = 0;
      chk("R8 rx-drain", flags[2], int'(RXV[v][0]));
    end
    chk("R2 ready low when full", rx_in_ready, 0);

    // R8 drain disabled
    rxclr(); rx_thr = 3; push_rx(2, 0); tick(1); clr_flags();
    drain_en_rx = 0; xfer_end = 1; tick(1); xfer_end = 0;
    chk("R8 drain disabled", flags[2], 0);

    // R2 order
    rxclr(); push_rx(3, 8'hA0); tick(1);
    chk("R2 order 0", host_rd_data, 8'hA0); hread();
    chk("R2 order 1", host_rd_data, 8'hA1); hread();
    chk("R2 order 2", host_rd_data, 8'hA2); hread();

    // R5 write-1-to-clear with re-set
    rxclr(); rx_thr = 1; push_rx(2, 0); tick(2);
    chk("R5 set", flags[0], 1);
    flag_clr = 5'h01; tick(1); flag_clr = 0;
    chk("R5 cleared", flags[0], 0);
    tick(1);
    chk("R5 re-set", flags[0], 1);
    hread(); hread(); tick(2); clr_flags(); tick(2);
    chk("R5 stays clear", flags[0], 0);

    // R10 access errors
    clr_flags(); hread();
    chk("R10 read empty", flags[4], 1);
    chk("R10 read empty level", rx_level, 0);
    txclr(); clr_flags();
    for (int i = 0; i < 32; i++) hwrite(i);
    chk("R10 no err", flags[4], 0);
    hwrite(8'h55);
    chk("R10 write full", flags[4], 1);
    chk("R10 write full level", tx_level, 32);

    // R6 DMA RX burst, R11 clear
    rxclr(); rx_thr = 3; dma_rx_en = 1;
    push_rx(6, 0); tick(1);
    chk("R6 req up", dma_rx_req, 1);
    hread(); hread(); hread();
    chk("R6 partial", dma_rx_req, 1);
    hread();
    chk("R6 burst done", dma_rx_req, 0);
    tick(2);
    chk("R6 below thr", dma_rx_req, 0);
    push_rx(4, 0); tick(1);
    chk("R6 re-arm", dma_rx_req, 1);
    rxclr();
    chk("R11 rx req", dma_rx_req, 0);
    chk("R11 rx level", rx_level, 0);
    dma_rx_en = 0;

    // R7 DMA TX burst, R11 clear
    txclr(); tx_thr = 1; dma_tx_en = 1; tick(2);
    chk("R7 req up", dma_tx_req, 1);
    hwrite(8'h11); tick(3);
    chk("R7 short burst holds", dma_tx_req, 1);
    hwrite(8'h22);
    chk("R7 burst done", dma_tx_req, 0);
    tick(2);
    chk("R7 not empty", dma_tx_req, 0);
    chk("R2 tx head", tx_out_data, 8'h11);
    tx_out_ready = 1; tick(1); tx_out_ready = 0;
    chk("R2 tx next", tx_out_data, 8'h22);
    tx_out_ready = 1; tick(1); tx_out_ready = 0;
    tick(2);
    chk("R7 empty again", dma_tx_req, 1);
    txclr();
    chk("R11 tx req", dma_tx_req, 0);
    chk("R11 tx level", tx_level, 0);
    dma_tx_en = 0;

    // R4, R9, R12 transmit transfer
    txclr(); tx_thr = 1; drain_en_tx = 1;
    xfer_len = 5; xfer_dir_tx = 1; xfer_start = 1; tick(1); xfer_start = 0;
    chk("R12 bus_left load", bus_left, 5);
    chk("R12 host_left load", host_left, 5);
    clr_flags(); tick(2);
    chk("R4 tx-ready", flags[1], 1);
    chk("R9 no drain yet", flags[3], 0);
    hwrite(1); hwrite(2); clr_flags(); tick(2);
    chk("R4 level above thr", flags[1], 0);
    hwrite(3); hwrite(4); tick(2);
    chk("R12 host_left", host_left, 1);
    chk("R9 tx-drain", flags[3], 1);
    tx_out_ready = 1; tick(2); tx_out_ready = 0;
    chk("R12 bus_left count", bus_left, 3);
    xfer_dir_tx = 0; xfer_len = 7; xfer_start = 1; tick(1); xfer_start = 0;
    chk("R12 rx dir host_left", host_left, 0);

    summary();
  end
endmodule